// File: doc/BRIEF.md
# Transport Packet PID Filter and Remapper

This block sits in a transport stream path and reduces one incoming multiplex to a single program. Bytes arrive one per transfer on a valid/ready stream with a start-of-packet marker. The block frames fixed-length packets and reads the 13-bit packet identifier. It keeps only four kinds of packet: the program association packets on identifier zero, and the packets on one programmed video identifier, one programmed audio identifier and one programmed clock-reference identifier. Each kept packet leaves with its identifier rewritten to a programmed replacement. Every other packet disappears without a trace on the output.

The block also marks each kept packet that carries a program clock reference. It raises a one-cycle error pulse when a packet does not begin with the sync byte. The first six bytes of each packet are held in a small buffer, so the keep or drop decision and the clock-reference mark are known before any byte of the packet is emitted. After the buffered header has been sent, the payload streams straight through, and output backpressure stalls the input on byte boundaries.

The controller has four states. COLLECT takes header bytes into the buffer. EMIT replays the buffered header. PASS forwards the payload. DROP swallows a rejected packet. The transitions are as follows:
- COLLECT to DROP on the third byte, when the sync byte is wrong or the identifier matches no entry.
- COLLECT to EMIT on the sixth byte of a kept packet.
- EMIT to PASS once the sixth buffered byte is accepted downstream.
- PASS to COLLECT and DROP to COLLECT on the last byte of the packet.

Top module: `ts_pid_remap`

## Requirements
- R1: Packets are PKT_LEN (188) bytes long. A kept packet is emitted whole and in order, starting with sync byte 0x47. Every byte is unchanged except the identifier bits. The identifier bits are bits 4:0 of byte 1 (the high part) and all of byte 2, so bits 7:5 of byte 1, including the error-indicator bit 7, pass through.
- R2: A packet is kept only when its identifier is 0x0000 or equals the video, audio or clock-reference setting. Any other packet produces no output byte.
- R3: The identifier of a kept packet is replaced by the replacement value of the entry it matches. When several entries match, the priority is identifier zero first, then video, then audio, then clock reference.
- R4: out_pcr is high on every byte of a kept packet when all of the following hold: its identifier equals the clock-reference setting, bit 5 of byte 3 is set (adaptation field present; the adaptation control is bits 5:4), byte 4 (adaptation length) is non-zero, and bit 4 of byte 5 is set. Otherwise out_pcr is low.
- R5: A packet whose byte 0 is not 0x47 is dropped whole. sync_err is high for exactly one cycle, in the cycle after that byte is accepted.
- R6: While the block waits for byte 0 of a packet, accepted bytes with in_sop low are discarded. in_sop on a byte inside a packet has no effect.
- R7: While out_valid is high and out_ready is low, out_valid stays high and out_data stays unchanged. out_sop is high only on byte 0 of an emitted packet.
- R8: After reset, out_valid and sync_err are low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_vid_pid | input | 13 | Video identifier to keep |
| cfg_aud_pid | input | 13 | Audio identifier to keep |
| cfg_pcr_pid | input | 13 | Clock-reference identifier to keep |
| cfg_pat_map | input | 13 | Replacement for identifier zero |
| cfg_vid_map | input | 13 | Replacement for video |
| cfg_aud_map | input | 13 | Replacement for audio |
| cfg_pcr_map | input | 13 | Replacement for clock reference |
| in_data | input | 8 | Input byte |
| in_valid | input | 1 | Input byte valid |
| in_sop | input | 1 | Input start-of-packet marker |
| in_ready | output | 1 | Block accepts the input byte |
| out_data | output | 8 | Output byte |
| out_valid | output | 1 | Output byte valid |
| out_sop | output | 1 | First byte of an output packet |
| out_pcr | output | 1 | Output packet carries a clock reference |
| out_ready | input | 1 | Downstream accepts the output byte |
| sync_err | output | 1 | One-cycle pulse for a bad sync byte |

## Verification
The checker watches every cycle for the stream rules: data held stable under backpressure, out_sop only at each 188-byte boundary, the sync value on every first byte, a clock-reference mark that stays constant through a packet, and single-cycle error pulses. Which packets survive, the replacement values and their priority order, the exact conditions for the clock-reference mark, hunting for the marker and the count of sync errors all depend on packet contents. Only the bench sweeps show these, by comparing the output byte for byte against packets it builds itself across identifiers, adaptation settings and flag values.

// File: rtl/ts_remap_pkg.sv
package ts_remap_pkg;

    typedef enum logic [1:0] {
        ST_COLLECT,
        ST_EMIT,
        ST_PASS,
        ST_DROP
    } ts_state_e;

    localparam logic [7:0] TS_SYNC    = 8'h47;
    localparam int         HDR_BYTES  = 6;
    localparam int         DECIDE_POS = 2;

    // match table entries, lowest index wins
    localparam int SEL_PAT = 0;
    localparam int SEL_VID = 1;
    localparam int SEL_AUD = 2;
    localparam int SEL_PCR = 3;
    localparam int SEL_N   = 4;

    // header bit positions
    localparam int AF_PRESENT_BIT = 5;
    localparam int PCR_FLAG_BIT   = 4;

endpackage

// File: rtl/ts_pos_counter.sv
module ts_pos_counter #(
    parameter int PKT_LEN = 188,
    localparam int POS_W  = $clog2(PKT_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [POS_W-1:0] pos,
    output logic             at_last
);

    assign at_last = (pos == POS_W'(PKT_LEN - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos <= '0;
        end else if (step) begin
            pos <= at_last ? '0 : pos + 1'b1;
        end
    end

endmodule

// File: rtl/ts_pid_match.sv
module ts_pid_match #(
    parameter int PID_W = 13,
    parameter int N     = 4
) (
    input  logic [PID_W-1:0]        pid,
    input  logic [N-1:0][PID_W-1:0] sel_pid,
    input  logic [N-1:0][PID_W-1:0] sel_map,
    output logic [N-1:0]            sel_eq,
    output logic                    hit,
    output logic [PID_W-1:0]        new_pid
);

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign sel_eq[g] = (pid == sel_pid[g]);
    end

    always_comb begin
        hit     = 1'b0;
        new_pid = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (sel_eq[i]) begin
                hit     = 1'b1;
                new_pid = sel_map[i];
            end
        end
    end

endmodule

// File: rtl/ts_pid_remap.sv
module ts_pid_remap
    import ts_remap_pkg::*;
#(
    parameter int PKT_LEN = 188,
    parameter int PID_W   = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PID_W-1:0] cfg_vid_pid,
    input  logic [PID_W-1:0] cfg_aud_pid,
    input  logic [PID_W-1:0] cfg_pcr_pid,
    input  logic [PID_W-1:0] cfg_pat_map,
    input  logic [PID_W-1:0] cfg_vid_map,
    input  logic [PID_W-1:0] cfg_aud_map,
    input  logic [PID_W-1:0] cfg_pcr_map,
    input  logic [7:0]       in_data,
    input  logic             in_valid,
    input  logic             in_sop,
    output logic             in_ready,
    output logic [7:0]       out_data,
    output logic             out_valid,
    output logic             out_sop,
    output logic             out_pcr,
    input  logic             out_ready,
    output logic             sync_err
);

    localparam int POS_W    = $clog2(PKT_LEN);
    localparam int PID_HI_W = PID_W - 8;
    localparam int EIDX_W   = $clog2(HDR_BYTES);

    ts_state_e state, state_nx;

    logic [POS_W-1:0]  pos;
    logic              at_last;
    logic              acc;
    logic              hunting;
    logic              step;
    logic [7:0]        hdr_q [HDR_BYTES];
    logic [EIDX_W-1:0] emit_idx;
    logic [PID_W-1:0]  new_pid_q;
    logic              pcr_pid_q;
    logic              pcr_mark_q;
    logic              sync_err_q;
    logic [7:0]        emit_byte;

    logic [PID_W-1:0]              pid_cur;
    logic [SEL_N-1:0][PID_W-1:0]   sel_pid;
    logic [SEL_N-1:0][PID_W-1:0]   sel_map;
    logic [SEL_N-1:0]              sel_eq;
    logic                          pid_hit;
    logic [PID_W-1:0]              match_pid;

    logic in_collect;
    logic at_decide;
    logic at_hdr_end;
    logic keep_now;

    // handshake
    assign acc     = in_valid && in_ready;
    assign hunting = (state == ST_COLLECT) && (pos == '0) && !in_sop;
    assign step    = acc && !hunting;

    ts_pos_counter #(.PKT_LEN(PKT_LEN)) u_pos (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (step),
        .pos     (pos),
        .at_last (at_last)
    );

    // identifier lookup on the third header byte
    assign pid_cur = {hdr_q[1][PID_HI_W-1:0], in_data};
    assign sel_pid = {cfg_pcr_pid, cfg_aud_pid, cfg_vid_pid, {PID_W{1'b0}}};
    assign sel_map = {cfg_pcr_map, cfg_aud_map, cfg_vid_map, cfg_pat_map};

    ts_pid_match #(.PID_W(PID_W), .N(SEL_N)) u_match (
        .pid     (pid_cur),
        .sel_pid (sel_pid),
        .sel_map (sel_map),
        .sel_eq  (sel_eq),
        .hit     (pid_hit),
        .new_pid (match_pid)
    );

    assign in_collect = (state == ST_COLLECT) && step;
    assign at_decide  = in_collect && (pos == POS_W'(DECIDE_POS));
    assign at_hdr_end = in_collect && (pos == POS_W'(HDR_BYTES - 1));
    assign keep_now   = (hdr_q[0] == TS_SYNC) && pid_hit;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_COLLECT;
        end else begin
            state <= state_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_COLLECT: begin
                if (at_decide && !keep_now) begin
                    state_nx = ST_DROP;
                end else if (at_hdr_end) begin
                    state_nx = ST_EMIT;
                end
            end
            ST_EMIT: begin
                if (out_ready && (emit_idx == EIDX_W'(HDR_BYTES - 1))) begin
                    state_nx = ST_PASS;
                end
            end
            ST_PASS: begin
                if (step && at_last) begin
                    state_nx = ST_COLLECT;
                end
            end
            ST_DROP: begin
                if (step && at_last) begin
                    state_nx = ST_COLLECT;
                end
            end
            default: state_nx = ST_COLLECT;
        endcase
    end

    // header buffer and per-packet decisions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < HDR_BYTES; i++) begin
                hdr_q[i] <= '0;
            end
            emit_idx   <= '0;
            new_pid_q  <= '0;
            pcr_pid_q  <= 1'b0;
            pcr_mark_q <= 1'b0;
            sync_err_q <= 1'b0;
        end else begin
            sync_err_q <= in_collect && (pos == '0) && (in_data != TS_SYNC);
            if (in_collect && (pos < POS_W'(HDR_BYTES))) begin
                hdr_q[pos[EIDX_W-1:0]] <= in_data;
            end
            if (at_decide) begin
                new_pid_q <= match_pid;
                pcr_pid_q <= sel_eq[SEL_PCR];
            end
            if (at_hdr_end) begin
                pcr_mark_q <= pcr_pid_q && hdr_q[3][AF_PRESENT_BIT]
                              && (hdr_q[4] != 8'h00) && in_data[PCR_FLAG_BIT];
            end
            if ((state == ST_EMIT) && out_ready) begin
                emit_idx <= (emit_idx == EIDX_W'(HDR_BYTES - 1)) ? '0 : emit_idx + 1'b1;
            end
        end
    end

    // buffered header byte with the identifier rewritten
    always_comb begin
        emit_byte = hdr_q[emit_idx];
        if (emit_idx == EIDX_W'(1)) begin
            emit_byte = {hdr_q[1][7:PID_HI_W], new_pid_q[PID_W-1:8]};
        end else if (emit_idx == EIDX_W'(DECIDE_POS)) begin
            emit_byte = new_pid_q[7:0];
        end
    end

    // outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_data  = 8'h00;
        out_sop   = 1'b0;
        out_pcr   = 1'b0;
        unique case (state)
            ST_COLLECT: begin
                in_ready = 1'b1;
            end
            ST_EMIT: begin
                out_valid = 1'b1;
                out_data  = emit_byte;
                out_sop   = (emit_idx == '0);
                out_pcr   = pcr_mark_q;
            end
            ST_PASS: begin
                in_ready  = out_ready;
                out_valid = in_valid;
                out_data  = in_data;
                out_pcr   = pcr_mark_q;
            end
            ST_DROP: begin
                in_ready = 1'b1;
            end
            default: begin
                in_ready = 1'b0;
            end
        endcase
    end

    assign sync_err = sync_err_q;

endmodule

// File: rtl/ts_pid_remap_chk.sv
module ts_pid_remap_chk #(
    parameter int PKT_LEN = 188
) (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] out_data,
    input logic       out_valid,
    input logic       out_sop,
    input logic       out_pcr,
    input logic       out_ready,
    input logic       sync_err
);

    localparam int CW = $clog2(PKT_LEN);

    logic [CW-1:0] ocnt;
    logic          pcr_hold;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ocnt     <= '0;
            pcr_hold <= 1'b0;
        end else if (out_valid && out_ready) begin
            ocnt <= (ocnt == CW'(PKT_LEN - 1)) ? '0 : ocnt + 1'b1;
            if (ocnt == '0) begin
                pcr_hold <= out_pcr;
            end
        end
    end

    a_r7_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sop));

    a_r7_sop_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_sop == (ocnt == '0)));

    a_r1_sync_leads: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_sop |-> out_data == 8'h47);

    a_r4_mark_steady: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (ocnt != '0) |-> out_pcr == pcr_hold);

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err |=> !sync_err);

endmodule

bind ts_pid_remap ts_pid_remap_chk #(.PKT_LEN(PKT_LEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_data  (out_data),
    .out_valid (out_valid),
    .out_sop   (out_sop),
    .out_pcr   (out_pcr),
    .out_ready (out_ready),
    .sync_err  (sync_err)
);

// File: tb/ts_pid_remap_bench.sv
module ts_pid_remap_bench;

    localparam int PKT = 188;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] cfg_vid_pid = 13'h100, cfg_aud_pid = 13'h101, cfg_pcr_pid = 13'h102;
    logic [12:0] cfg_pat_map = 13'h000, cfg_vid_map = 13'h1A0;
    logic [12:0] cfg_aud_map = 13'h0A1, cfg_pcr_map = 13'h1FA2;
    logic [7:0]  in_data = 8'h00;
    logic        in_valid = 1'b0, in_sop = 1'b0, out_ready = 1'b1;
    logic        in_ready, out_valid, out_sop, out_pcr, sync_err;
    logic [7:0]  out_data;

    always #5 clk = ~clk;

    ts_pid_remap u_ts_pid_remap (
        .clk(clk), .rst_n(rst_n),
        .cfg_vid_pid(cfg_vid_pid), .cfg_aud_pid(cfg_aud_pid), .cfg_pcr_pid(cfg_pcr_pid),
        .cfg_pat_map(cfg_pat_map), .cfg_vid_map(cfg_vid_map),
        .cfg_aud_map(cfg_aud_map), .cfg_pcr_map(cfg_pcr_map),
        .in_data(in_data), .in_valid(in_valid), .in_sop(in_sop), .in_ready(in_ready),
        .out_data(out_data), .out_valid(out_valid), .out_sop(out_sop),
        .out_pcr(out_pcr), .out_ready(out_ready), .sync_err(sync_err)
    );

    int n_tests = 0, n_fail = 0;
    logic [7:0] exp_q[$];
    logic       exp_pcr_q[$];
    string      tag_q[$];
    int exp_sync_err = 0, seen_sync_err = 0, kept_n = 0, seen_pkts = 0;
    bit bp_on = 0, gap_on = 0, done = 0;
    int gcnt = 0, cyc = 0;

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // output ready pattern
    initial begin
        forever begin
            @(posedge clk); #1;
            cyc++;
            out_ready = bp_on ? (((cyc * 7) % 5) < 3) : 1'b1;
        end
    end

    // monitor
    int oidx = 0, pkt_bad = 0, bad_act = 0, bad_exp = 0;
    logic cur_pcr = 0;
    string cur_tag = "R1";
    always @(negedge clk) begin
        if (rst_n && sync_err) seen_sync_err++;
        if (rst_n && out_valid && out_ready) begin
            if (oidx == 0) begin
                if (exp_pcr_q.size() == 0) begin
                    check(0, "R2", "byte from a packet that must be dropped", out_data, 0);
                end else begin
                    cur_pcr = exp_pcr_q.pop_front();
                    cur_tag = tag_q.pop_front();
                end
                pkt_bad = 0;
            end
            if (exp_q.size() != 0) begin
                logic [7:0] e;
                e = exp_q.pop_front();
                if (pkt_bad == 0 && (out_data != e || out_sop != (oidx == 0) || out_pcr != cur_pcr)) begin
                    pkt_bad = 1;
                    bad_act = {oidx, out_sop, out_pcr, out_data};
                    bad_exp = {oidx, (oidx == 0), cur_pcr, e};
                end
            end
            if (oidx == PKT - 1) begin
                check(pkt_bad == 0, cur_tag, "packet content {pos,sop,pcr,byte}", bad_act, bad_exp);
                seen_pkts++;
                oidx = 0;
            end else begin
                oidx++;
            end
        end
    end

    task automatic send_byte(logic [7:0] b, logic s);
        in_data  = b;
        in_sop   = s;
        in_valid = 1'b1;
        do @(negedge clk); while (!in_ready);
        @(posedge clk); #1;
        in_valid = 1'b0;
        in_sop   = 1'b0;
        if (gap_on && (gcnt++ % 3 == 0)) begin
            @(posedge clk); #1;
        end
    endtask

    function automatic logic [7:0] pkt_byte(int pos, int pid, int afc, int aflen,
                                            int afflags, int sync, int tei, int idx);
        case (pos)
            0: return 8'(sync);
            1: return {1'(tei), 2'(idx), 5'(pid >> 8)};
            2: return 8'(pid);
            3: return {2'b00, 2'(afc), 4'(idx)};
            4: return 8'(aflen);
            5: return 8'(afflags);
            default: return 8'(idx * 7 + pos);
        endcase
    endfunction

    task automatic send_pkt(int pid, int afc, int aflen, int afflags, int sync,
                            int tei, int idx, string tag, int mid_sop);
        bit keep, pcr;
        logic [12:0] np;
        keep = (sync == 8'h47) && (pid == 0 || pid == cfg_vid_pid ||
               pid == cfg_aud_pid || pid == cfg_pcr_pid);
        np = (pid == 0) ? cfg_pat_map : (pid == cfg_vid_pid) ? cfg_vid_map :
             (pid == cfg_aud_pid) ? cfg_aud_map : cfg_pcr_map;
        pcr = (pid == cfg_pcr_pid) && afc[1] && (aflen != 0) && afflags[4];
        if (sync != 8'h47) exp_sync_err++;
        if (keep) begin
            kept_n++;
            exp_pcr_q.push_back(pcr);
            tag_q.push_back(tag);
            for (int p = 0; p < PKT; p++) begin
                logic [7:0] b;
                b = pkt_byte(p, pid, afc, aflen, afflags, sync, tei, idx);
                if (p == 1) b[4:0] = np[12:8];
                if (p == 2) b = np[7:0];
                exp_q.push_back(b);
            end
        end
        for (int p = 0; p < PKT; p++) begin
            send_byte(pkt_byte(p, pid, afc, aflen, afflags, sync, tei, idx),
                      (p == 0) || (mid_sop > 0 && p == mid_sop));
        end
    endtask

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int pids[8];
        int idx;
        pids = '{0, 'h100, 'h101, 'h102, 'h1FFF, 'h0FF, 'h1100, 'h103};
        idx = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        check(out_valid == 0, "R8", "out_valid after reset", out_valid, 0);
        check(in_ready == 1, "R8", "in_ready after reset", in_ready, 1);
        check(sync_err == 0, "R8", "sync_err after reset", sync_err, 0);
        @(posedge clk); #1;

        // sweep identifiers, adaptation control and flag variants (R1 R2 R3 R4)
        for (int p = 0; p < 8; p++) begin
            for (int a = 0; a < 4; a++) begin
                for (int v = 0; v < 3; v++) begin
                    send_pkt(pids[p], a, (v == 0) ? 0 : 5, (v == 2) ? 'hEF : 'h10,
                             'h47, (p + a) % 2, idx++,
                             (pids[p] == 'h102) ? "R4" : "R3", 0);
                end
            end
        end

        // backpressure and input gaps (R7)
        bp_on = 1; gap_on = 1;
        for (int p = 0; p < 8; p++) begin
            send_pkt(pids[p], 3, 5, 'h10, 'h47, 1, idx++, "R7", 0);
            send_pkt(pids[p], 1, 0, 'h00, 'h47, 0, idx++, "R7", 0);
        end
        bp_on = 0; gap_on = 0;

        // bad sync byte (R5)
        send_pkt('h100, 1, 0, 0, 'h46, 0, idx++, "R5", 0);
        send_pkt('h100, 1, 0, 0, 'h47, 0, idx++, "R5", 0);
        send_pkt('h101, 3, 2, 'h10, 'hB8, 1, idx++, "R5", 0);
        send_pkt('h102, 3, 2, 'h10, 'h47, 1, idx++, "R5", 0);

        // hunting and mid-packet marker (R6)
        for (int j = 0; j < 5; j++) send_byte(8'h47, 1'b0);
        send_pkt('h101, 1, 0, 0, 'h47, 0, idx++, "R6", 90);
        send_pkt('h100, 2, 7, 'h10, 'h47, 0, idx++, "R6", 3);

        // overlapping entries, priority (R3)
        cfg_pcr_pid = 13'h100;
        send_pkt('h100, 3, 7, 'h10, 'h47, 0, idx++, "R3", 0);
        cfg_aud_pid = 13'h100;
        send_pkt('h100, 2, 7, 'h10, 'h47, 1, idx++, "R3", 0);
        cfg_vid_pid = 13'h000;
        send_pkt('h000, 3, 7, 'h10, 'h47, 0, idx++, "R3", 0);
        send_pkt('h100, 3, 7, 'h00, 'h47, 0, idx++, "R3", 0);

        repeat (4 * PKT) @(posedge clk);
        check(exp_q.size() == 0, "R2", "expected bytes left over", exp_q.size(), 0);
        check(seen_pkts == kept_n, "R2", "emitted packet count", seen_pkts, kept_n);
        check(seen_sync_err == exp_sync_err, "R5", "sync error pulses", seen_sync_err, exp_sync_err);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule